// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block maps a virtual address to a physical address in two table steps. The top bits of the virtual address choose a segment. The segment's entry supplies three things: where that segment's page entries begin in a shared page-entry array, how many pages the segment holds, and the rights the segment grants. The middle bits give a page number. The page number is checked against the segment's page count and then added to the segment's starting point to pick one page entry. That entry gives a frame number and page-level rights. The low bits pass through unchanged as the offset. A request that fails any check gets a fault code back in place of an address.

Both tables are register arrays, and each has its own write port for configuration. One request can be accepted on every clock. The verdict appears one cycle later on registered outputs, driven from a small response state machine with three states:

- RS_IDLE: no response this cycle.
- RS_DONE: translation succeeded.
- RS_FAULT: a check failed.

Every cycle the machine makes one of three transitions, whatever its present state:

- Any state to RS_IDLE when no request is presented.
- Any state to RS_DONE when a request passes every check.
- Any state to RS_FAULT when a request fails a check.

A rights field has two bits. Bit 0 means access is allowed (for a page entry, that the page is present). Bit 1 means writes are allowed. Bit 1 only counts when bit 0 is set.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and every segment's page count is 0. A request to any segment therefore answers with fault code 1.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with req_valid high, and 0 after a cycle with req_valid low.
- R3: If the page number is at or above the segment's page count, the response faults with code 1. This check has the highest priority.
- R4: If R3 passes, a segment whose rights bit 0 is clear, or a write to a segment whose rights bit 1 is clear, faults with code 2.
- R5: If R3 and R4 pass, a page entry whose rights bit 0 is clear (not present) faults with code 3.
- R6: If R3 to R5 pass, a write to a page entry whose rights bit 1 is clear (read-only) faults with code 4.
- R7: A request that passes every check returns rsp_fault 0, rsp_code 0, and rsp_paddr equal to {frame, offset}. The frame is taken from page entry (segment start + page number) modulo PT_DEPTH.
- R8: A faulting response drives rsp_paddr to 0 and a nonzero rsp_code.
- R9: A table write takes effect for the first request presented in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_seg_we | input | 1 | Write enable for a segment entry |
| cfg_seg_idx | input | SEG_W | Segment entry to write |
| cfg_seg_start | input | PTR_W | First page-entry index of the segment |
| cfg_seg_len | input | PAGE_W+1 | Number of pages in the segment |
| cfg_seg_rights | input | 2 | Segment rights (bit 0 access, bit 1 write) |
| cfg_pte_we | input | 1 | Write enable for a page entry |
| cfg_pte_idx | input | PTR_W | Page entry to write |
| cfg_pte_frame | input | FRAME_W | Frame number |
| cfg_pte_rights | input | 2 | Page rights (bit 0 present, bit 1 write) |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | SEG_W+PAGE_W+OFF_W | Virtual address {segment, page, offset} |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address, 0 on fault |
| rsp_code | output | 3 | 0 ok, 1 segment bound, 2 segment rights, 3 page absent, 4 page read-only |

## Verification
The bench builds the block with its default parameters:

- 16 segments.
- 256 pages per segment.
- 12-bit offsets.
- A 64-entry page array.

At this size every segment and every page number can be swept with both a read and a write. Segment page counts run from 0 up to the full 256. All four rights codes are spread over segments and pages, so each fault priority is reached. Segment start points combined with large page numbers run past entry 63, which exercises the modulo wrap of the page index. Rewrites of a page entry and of a segment's rights, followed by new requests, show that table updates are picked up on the next request.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [2:0] {
        V_OK           = 3'd0,
        V_SEG_BOUND    = 3'd1,
        V_SEG_RIGHTS   = 3'd2,
        V_PAGE_ABSENT  = 3'd3,
        V_PAGE_RO      = 3'd4
    } verdict_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DONE  = 2'd1,
        RS_FAULT = 2'd2
    } rsp_state_e;

    localparam int RIGHT_ACCESS = 0;
    localparam int RIGHT_WRITE  = 1;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 4,
    parameter int PTR_W = 6,
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEG_W-1:0] widx,
    input  logic [PTR_W-1:0] wstart,
    input  logic [LEN_W-1:0] wlen,
    input  logic [1:0]       wrights,
    input  logic [SEG_W-1:0] ridx,
    output logic [PTR_W-1:0] rstart,
    output logic [LEN_W-1:0] rlen,
    output logic [1:0]       rrights
);
    localparam int NSEG = 1 << SEG_W;

    logic [PTR_W-1:0] start_q  [NSEG];
    logic [LEN_W-1:0] len_q    [NSEG];
    logic [1:0]       rights_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[g]  <= '0;
                len_q[g]    <= '0;
                rights_q[g] <= '0;
            end else if (we && widx == SEG_W'(g)) begin
                start_q[g]  <= wstart;
                len_q[g]    <= wlen;
                rights_q[g] <= wrights;
            end
        end
    end

    assign rstart  = start_q[ridx];
    assign rlen    = len_q[ridx];
    assign rrights = rights_q[ridx];
endmodule

// File: rtl/page_table.sv
module page_table #(
    parameter int PTR_W   = 6,
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PTR_W-1:0]   widx,
    input  logic [FRAME_W-1:0] wframe,
    input  logic [1:0]         wrights,
    input  logic [PTR_W-1:0]   ridx,
    output logic [FRAME_W-1:0] rframe,
    output logic [1:0]         rrights
);
    localparam int DEPTH = 1 << PTR_W;

    logic [FRAME_W-1:0] frame_q  [DEPTH];
    logic [1:0]         rights_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_pte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[g]  <= '0;
                rights_q[g] <= '0;
            end else if (we && widx == PTR_W'(g)) begin
                frame_q[g]  <= wframe;
                rights_q[g] <= wrights;
            end
        end
    end

    assign rframe  = frame_q[ridx];
    assign rrights = rights_q[ridx];
endmodule

// File: rtl/rights_check.sv
module rights_check
    import xlate_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = PAGE_W + 1
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic [1:0]        seg_rights,
    input  logic [1:0]        pte_rights,
    input  logic              is_write,
    output verdict_e          verdict
);
    always_comb begin
        if (LEN_W'(page) >= seg_len)
            verdict = V_SEG_BOUND;
        else if (!seg_rights[RIGHT_ACCESS] || (is_write && !seg_rights[RIGHT_WRITE]))
            verdict = V_SEG_RIGHTS;
        else if (!pte_rights[RIGHT_ACCESS])
            verdict = V_PAGE_ABSENT;
        else if (is_write && !pte_rights[RIGHT_WRITE])
            verdict = V_PAGE_RO;
        else
            verdict = V_OK;
    end
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
    import xlate_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 12,
    parameter int PTR_W   = 6,
    parameter int FRAME_W = 12,
    localparam int LEN_W  = PAGE_W + 1,
    localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_seg_we,
    input  logic [SEG_W-1:0]   cfg_seg_idx,
    input  logic [PTR_W-1:0]   cfg_seg_start,
    input  logic [LEN_W-1:0]   cfg_seg_len,
    input  logic [1:0]         cfg_seg_rights,
    input  logic               cfg_pte_we,
    input  logic [PTR_W-1:0]   cfg_pte_idx,
    input  logic [FRAME_W-1:0] cfg_pte_frame,
    input  logic [1:0]         cfg_pte_rights,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [2:0]         rsp_code
);
    logic [SEG_W-1:0]   va_seg;
    logic [PAGE_W-1:0]  va_page;
    logic [OFF_W-1:0]   va_off;
    logic [PTR_W-1:0]   seg_start;
    logic [LEN_W-1:0]   seg_len;
    logic [1:0]         seg_rights;
    logic [PTR_W-1:0]   pte_idx;
    logic [FRAME_W-1:0] pte_frame;
    logic [1:0]         pte_rights;
    verdict_e           verdict;

    rsp_state_e         state_q, state_d;
    logic [PA_W-1:0]    paddr_q;
    logic [2:0]         code_q;

    assign {va_seg, va_page, va_off} = req_vaddr;
    assign pte_idx = seg_start + PTR_W'(va_page);

    seg_table #(.SEG_W(SEG_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_seg (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_seg_we), .widx(cfg_seg_idx), .wstart(cfg_seg_start),
        .wlen(cfg_seg_len), .wrights(cfg_seg_rights),
        .ridx(va_seg), .rstart(seg_start), .rlen(seg_len), .rrights(seg_rights)
    );

    page_table #(.PTR_W(PTR_W), .FRAME_W(FRAME_W)) u_pte (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_pte_we), .widx(cfg_pte_idx), .wframe(cfg_pte_frame),
        .wrights(cfg_pte_rights),
        .ridx(pte_idx), .rframe(pte_frame), .rrights(pte_rights)
    );

    rights_check #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chk (
        .page(va_page), .seg_len(seg_len), .seg_rights(seg_rights),
        .pte_rights(pte_rights), .is_write(req_write), .verdict(verdict)
    );

    // Next-state: the response state depends only on this cycle's request.
    always_comb begin
        state_d = RS_IDLE;
        if (req_valid)
            state_d = (verdict == V_OK) ? RS_DONE : RS_FAULT;
    end

    // State register with captured response data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            paddr_q <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                paddr_q <= (verdict == V_OK) ? {pte_frame, va_off} : '0;
                code_q  <= verdict;
            end
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_paddr = '0;
        rsp_code  = '0;
        unique case (state_q)
            RS_IDLE: ;
            RS_DONE: begin
                rsp_valid = 1'b1;
                rsp_paddr = paddr_q;
            end
            RS_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                rsp_code  = code_q;
            end
            default: ;
        endcase
    end

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r3_bound_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (LEN_W'(va_page) >= seg_len)) |=> (rsp_fault && rsp_code == 3'd1));
    a_r6_write_needs_both_rights: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && verdict == V_OK) |-> (seg_rights[1] && pte_rights[1]));
    a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == $past(va_off)));
    a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && rsp_code != 3'd0));
endmodule

// File: tb/seg_page_xlate_tb.sv
module seg_page_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_seg_we;
    logic [3:0]  cfg_seg_idx;
    logic [5:0]  cfg_seg_start;
    logic [8:0]  cfg_seg_len;
    logic [1:0]  cfg_seg_rights;
    logic        cfg_pte_we;
    logic [5:0]  cfg_pte_idx;
    logic [11:0] cfg_pte_frame;
    logic [1:0]  cfg_pte_rights;
    logic        req_valid;
    logic [23:0] req_vaddr;
    logic        req_write;
    logic        rsp_valid, rsp_fault;
    logic [23:0] rsp_paddr;
    logic [2:0]  rsp_code;

    int n_checks = 0;
    int n_errors = 0;

    int m_start [16];
    int m_len   [16];
    int m_srt   [16];
    int m_frame [64];
    int m_prt   [64];

    always #5 clk = ~clk;

    seg_page_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_seg_we(cfg_seg_we), .cfg_seg_idx(cfg_seg_idx), .cfg_seg_start(cfg_seg_start),
        .cfg_seg_len(cfg_seg_len), .cfg_seg_rights(cfg_seg_rights),
        .cfg_pte_we(cfg_pte_we), .cfg_pte_idx(cfg_pte_idx), .cfg_pte_frame(cfg_pte_frame),
        .cfg_pte_rights(cfg_pte_rights),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_code(rsp_code)
    );

    task automatic write_seg(input int s, input int st, input int len, input int rt);
        @(negedge clk);
        cfg_seg_we = 1'b1; cfg_seg_idx = 4'(s); cfg_seg_start = 6'(st);
        cfg_seg_len = 9'(len); cfg_seg_rights = 2'(rt);
        @(negedge clk);
        cfg_seg_we = 1'b0;
        m_start[s] = st; m_len[s] = len; m_srt[s] = rt;
    endtask

    task automatic write_pte(input int i, input int fr, input int rt);
        @(negedge clk);
        cfg_pte_we = 1'b1; cfg_pte_idx = 6'(i); cfg_pte_frame = 12'(fr); cfg_pte_rights = 2'(rt);
        @(negedge clk);
        cfg_pte_we = 1'b0;
        m_frame[i] = fr; m_prt[i] = rt;
    endtask

    // Sends one request and checks the response one cycle later against the model.
    task automatic check_req(input int s, input int pg, input int off, input bit wr, input string why);
        int code, idx, paddr;
        string tag;
        code = 0; paddr = 0;
        if (pg >= m_len[s]) code = 1;
        else if (m_srt[s][0] == 0 || (wr && m_srt[s][1] == 0)) code = 2;
        else begin
            idx = (m_start[s] + pg) % 64;
            if (m_prt[idx][0] == 0) code = 3;
            else if (wr && m_prt[idx][1] == 0) code = 4;
            else paddr = m_frame[idx] * 4096 + off;
        end
        case (code)
            0: tag = "R7"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5"; default: tag = "R6";
        endcase
        req_valid = 1'b1; req_write = wr;
        req_vaddr = 24'(s * (1 << 20) + pg * 4096 + off);
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_fault !== (code != 0) || rsp_code !== 3'(code)
            || rsp_paddr !== 24'(paddr)) begin
            n_errors++;
            $display("FAIL %s/R8 %s seg=%0d page=%0d wr=%0d: got v=%0b f=%0b code=%0d pa=%h, expected v=1 f=%0b code=%0d pa=%h",
                     tag, why, s, pg, wr, rsp_valid, rsp_fault, rsp_code, rsp_paddr,
                     code != 0, code, 24'(paddr));
        end
    endtask

    task automatic check_idle(input string why);
        req_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL %s: rsp_valid got %0b expected 0", why, rsp_valid);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_seg_we = 0; cfg_pte_we = 0; req_valid = 0; req_write = 0;
        req_vaddr = '0; cfg_seg_idx = '0; cfg_seg_start = '0; cfg_seg_len = '0;
        cfg_seg_rights = '0; cfg_pte_idx = '0; cfg_pte_frame = '0; cfg_pte_rights = '0;
        for (int s = 0; s < 16; s++) begin m_start[s] = 0; m_len[s] = 0; m_srt[s] = 0; end
        for (int i = 0; i < 64; i++) begin m_frame[i] = 0; m_prt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: rsp_valid after reset got %0b expected 0", rsp_valid);
        end
        check_req(3, 0, 5, 1'b0, "R1 empty segment");
        check_req(15, 255, 0, 1'b1, "R1 empty segment");
        check_idle("R2 no request");
        // Tables: mixed counts, starts and rights, including wrap of the page index.
        for (int s = 0; s < 16; s++)
            write_seg(s, (s * 13) % 64, (s == 15) ? 256 : s * 3, s % 4);
        for (int i = 0; i < 64; i++)
            write_pte(i, (i * 37 + 5) % 4096, (i * 7) % 4);
        check_idle("R2 after config");
        // Exhaustive sweep: every segment, every page, read and write.
        for (int s = 0; s < 16; s++)
            for (int pg = 0; pg < 256; pg++)
                for (int w = 0; w < 2; w++)
                    check_req(s, pg, (s * 291 + pg * 13 + w) % 4096, w[0], "sweep");
        check_idle("R2 gap after burst");
        // R9: page entry rewrite picked up by the next request (seg 15 rw, page 10 -> idx 205%64=13).
        write_pte(13, 12'hABC, 3);
        check_req(15, 10, 12'h123, 1'b1, "R9 new frame");
        write_pte(13, 12'hABC, 1);
        check_req(15, 10, 12'h456, 1'b1, "R9 now read-only");
        check_req(15, 10, 12'h456, 1'b0, "R9 read still ok");
        write_seg(15, 9, 256, 1);
        check_req(15, 4, 12'h001, 1'b1, "R9 segment now read-only");
        check_req(15, 4, 12'h001, 1'b0, "R9 segment read");
        check_idle("R2 final");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule